// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital controller of a 10-bit successive-approximation converter. Software enables it, sets a start bit and picks one of eight acquisition lengths. Every state change is paced by a conversion-clock tick (TAD) that arrives one system clock at a time. While idle and enabled, the block keeps the sample switch closed so that the hold capacitor tracks the input. After a start it runs the selected automatic acquisition. It then opens the switch, spends one TAD discharging the capacitor array, and resolves ten bits, the most significant first, by presenting trial codes to the DAC and reading one comparator decision.

The result register is written, the busy bit drops and the sticky interrupt flag rises one system clock after the last bit decision. Software may clear the start bit at any moment to abandon a conversion, and the result register then keeps its old value. After a conversion finishes or is abandoned, two TAD of recovery pass with the sample switch open. Acquisition then resumes by itself. Software may also load the result register directly while the sequencer is idle.

Top module: `sar_seq`

## Requirements
- R1: After synchronous reset, result is 0, busy and flag are 0, and the block is disabled with sample, discharge and dac_code all 0. When enabled and idle, sample is 1. sample and discharge are never 1 together.
- R2: A control write with ctrl_go=1 sets busy only when the block was already enabled before that write and is idle and acquiring. A write with ctrl_en=1 and ctrl_go=1 to a disabled block enables it but leaves busy at 0.
- R3: The acquisition code selects N TAD: 000=0, 001=2, 010=4, 011=6, 100=8, 101=12, 110=16, 111=20. Exactly 12+N TAD ticks are consumed while busy: one tick leaves idle, then N ticks of acquisition with sample=1, then one discharge tick, then ten bit ticks.
- R4: The discharge TAD holds discharge=1, sample=0 and dac_code=0. The first trial code after it has only bit 9 set (value 512).
- R5: Each trial code is the bits already decided with the current bit added. The current bit is kept when cmp_ge=1 (input at or above the trial level). With an ideal comparator the result equals the input code, and the second trial is 768 when the input is 512 or more and 256 otherwise.
- R6: On the system clock after the clock that consumed the last bit tick, result takes the decided code, busy clears and flag rises. These outputs are therefore seen changed two clocks after that tick is sampled.
- R7: A control write with ctrl_en=1 and ctrl_go=0 while busy abandons the conversion. busy is 0 after that clock edge, result keeps its previous value and flag is not set.
- R8: After a completion or an abandonment, sample stays 0 for exactly 2 TAD ticks and then returns to 1. A start written during this wait is ignored, so busy stays 0.
- R9: flag stays 1 until a flag_clr pulse clears it.
- R10: A res_wr write while idle places res_wdata in result. The value holds until the next completed conversion replaces it.
- R11: A control write with ctrl_en=0 disables the block at once. An ongoing conversion ends with busy=0, sample=0, result unchanged and flag not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_wr | input | 1 | Control write strobe carrying ctrl_en and ctrl_go |
| ctrl_en | input | 1 | Enable value written |
| ctrl_go | input | 1 | Start bit value written (0 while busy abandons) |
| acq_code | input | 3 | Automatic acquisition length code |
| tad_tick | input | 1 | One-clock conversion-clock pulse |
| cmp_ge | input | 1 | Comparator: input at or above trial level |
| res_wr | input | 1 | Software write strobe for the result register |
| res_wdata | input | 10 | Value for a software result write |
| flag_clr | input | 1 | Clears the interrupt flag |
| sample | output | 1 | Sample switch closed (hold capacitor tracks input) |
| discharge | output | 1 | Capacitor-array discharge control |
| dac_code | output | 10 | Trial code to the DAC, 0 outside bit trials |
| result | output | 10 | Conversion result register |
| busy | output | 1 | Start/busy status bit |
| flag | output | 1 | Sticky completion interrupt flag |

## Verification
A start or abandon write is visible on busy one clock after the write edge. A TAD tick that is seen in a sample is consumed at the next rising edge. result, busy and flag change two clocks after the last bit tick is seen. The recovery wait ends one clock after its second tick. The bench drives inputs and samples outputs on falling edges. It counts ticks and clocks between these events, so that every comparison lands on the cycle in which the value is due and does not merely wait for the value to appear.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

   typedef enum logic [2:0] {
      ST_OFF,
      ST_IDLE,
      ST_ACQ,
      ST_DISCH,
      ST_BIT,
      ST_LOAD,
      ST_REC
   } seq_state_e;

   // longest automatic acquisition any code can select, in TAD
   localparam int ACQ_MAX_TADS = 20;

   // acquisition length in TAD for each 3-bit code
   function automatic int acq_tads(input logic [2:0] code);
      case (code)
         3'd0:    return 0;
         3'd1:    return 2;
         3'd2:    return 4;
         3'd3:    return 6;
         3'd4:    return 8;
         3'd5:    return 12;
         3'd6:    return 16;
         default: return ACQ_MAX_TADS;
      endcase
   endfunction

endpackage

// File: rtl/sar_tad_counter.sv
// Down-counter in TAD units, shared by acquisition and recovery phases.
module sar_tad_counter #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic             last
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (tick && (cnt_q != '0))
         cnt_q <= cnt_q - 1'b1;
   end

   assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/sar_trial_reg.sv
// Successive-approximation register: bit pointer plus decided bits.
module sar_trial_reg #(
   parameter int RES_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clear,
   input  logic             step,
   input  logic             cmp_ge,
   output logic [RES_W-1:0] trial,
   output logic [RES_W-1:0] decided,
   output logic             last
);

   localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
   localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(RES_W - 1);

   logic [IDX_W-1:0] idx_q;
   logic [RES_W-1:0] sel;

   always_ff @(posedge clk) begin
      if (rst || clear)
         idx_q <= IDX_TOP;
      else if (step && (idx_q != '0))
         idx_q <= idx_q - 1'b1;
   end

   for (genvar i = 0; i < RES_W; i++) begin : g_bit
      assign sel[i] = (idx_q == IDX_W'(i));

      always_ff @(posedge clk) begin
         if (rst || clear)
            decided[i] <= 1'b0;
         else if (step && sel[i] && cmp_ge)
            decided[i] <= 1'b1;
      end
   end

   assign trial = decided | sel;
   assign last  = sel[0];

endmodule

// File: rtl/sar_result_reg.sv
// Result register and sticky completion flag.
module sar_result_reg #(
   parameter int RES_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [RES_W-1:0] load_val,
   input  logic             sw_wr,
   input  logic [RES_W-1:0] sw_val,
   input  logic             flag_clr,
   output logic [RES_W-1:0] result,
   output logic             flag
);

   always_ff @(posedge clk) begin
      if (rst) begin
         result <= '0;
         flag   <= 1'b0;
      end else begin
         if (load)
            result <= load_val;
         else if (sw_wr)
            result <= sw_val;

         if (load)
            flag <= 1'b1;
         else if (flag_clr)
            flag <= 1'b0;
      end
   end

endmodule

// File: rtl/sar_seq.sv
module sar_seq
   import sar_seq_pkg::*;
#(
   parameter int RES_W    = 10,
   parameter int REC_TADS = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ctrl_wr,
   input  logic             ctrl_en,
   input  logic             ctrl_go,
   input  logic [2:0]       acq_code,
   input  logic             tad_tick,
   input  logic             cmp_ge,
   input  logic             res_wr,
   input  logic [RES_W-1:0] res_wdata,
   input  logic             flag_clr,
   output logic             sample,
   output logic             discharge,
   output logic [RES_W-1:0] dac_code,
   output logic [RES_W-1:0] result,
   output logic             busy,
   output logic             flag
);

   localparam int CNT_MAX = (ACQ_MAX_TADS > REC_TADS) ? ACQ_MAX_TADS : REC_TADS;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] REC_VAL = CNT_W'(REC_TADS);

   if (RES_W < 2) begin : g_bad_res
      $error("sar_seq: RES_W must be at least 2");
   end
   if (REC_TADS < 1) begin : g_bad_rec
      $error("sar_seq: REC_TADS must be at least 1");
   end

   seq_state_e       state_q, state_d;
   logic             go_q, go_d;
   logic             en_q, en_d;
   logic             cnt_load;
   logic [CNT_W-1:0] cnt_val;
   logic             cnt_last;
   logic [CNT_W-1:0] acq_n;
   logic [RES_W-1:0] trial;
   logic [RES_W-1:0] decided;
   logic             bit_last;
   logic             in_bit;
   logic             in_load;

   assign acq_n   = CNT_W'(acq_tads(acq_code));
   assign in_bit  = (state_q == ST_BIT);
   assign in_load = (state_q == ST_LOAD);

   always_comb begin
      state_d  = state_q;
      go_d     = go_q;
      en_d     = en_q;
      cnt_load = 1'b0;
      cnt_val  = '0;

      // sequencing on TAD ticks (load cycle runs on the system clock)
      case (state_q)
         ST_IDLE: begin
            if (go_q && tad_tick) begin
               if (acq_n == '0) begin
                  state_d = ST_DISCH;
               end else begin
                  state_d  = ST_ACQ;
                  cnt_load = 1'b1;
                  cnt_val  = acq_n;
               end
            end
         end
         ST_ACQ:   if (tad_tick && cnt_last) state_d = ST_DISCH;
         ST_DISCH: if (tad_tick) state_d = ST_BIT;
         ST_BIT:   if (tad_tick && bit_last) state_d = ST_LOAD;
         ST_LOAD: begin
            state_d  = ST_REC;
            go_d     = 1'b0;
            cnt_load = 1'b1;
            cnt_val  = REC_VAL;
         end
         ST_REC:   if (tad_tick && cnt_last) state_d = ST_IDLE;
         default: ;
      endcase

      // software control writes override the sequencing
      if (ctrl_wr) begin
         en_d = ctrl_en;
         if (!ctrl_en) begin
            state_d = ST_OFF;
            go_d    = 1'b0;
         end else if (!en_q) begin
            state_d = ST_IDLE;
         end else if (ctrl_go) begin
            if ((state_q == ST_IDLE) && !go_q)
               go_d = 1'b1;
         end else if (go_q && !in_load) begin
            go_d     = 1'b0;
            state_d  = ST_REC;
            cnt_load = 1'b1;
            cnt_val  = REC_VAL;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_OFF;
         go_q    <= 1'b0;
         en_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         go_q    <= go_d;
         en_q    <= en_d;
      end
   end

   sar_tad_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .load     (cnt_load),
      .load_val (cnt_val),
      .tick     (tad_tick),
      .last     (cnt_last)
   );

   sar_trial_reg #(.RES_W(RES_W)) u_trial (
      .clk     (clk),
      .rst     (rst),
      .clear   (state_q == ST_DISCH),
      .step    (in_bit && tad_tick),
      .cmp_ge  (cmp_ge),
      .trial   (trial),
      .decided (decided),
      .last    (bit_last)
   );

   sar_result_reg #(.RES_W(RES_W)) u_res (
      .clk      (clk),
      .rst      (rst),
      .load     (in_load),
      .load_val (decided),
      .sw_wr    (res_wr),
      .sw_val   (res_wdata),
      .flag_clr (flag_clr),
      .result   (result),
      .flag     (flag)
   );

   assign sample    = (state_q == ST_IDLE) || (state_q == ST_ACQ);
   assign discharge = (state_q == ST_DISCH);
   assign dac_code  = in_bit ? trial : '0;
   assign busy      = go_q;

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
   parameter int RES_W = 10
) (
   input logic             clk,
   input logic             rst,
   input logic             ctrl_wr,
   input logic             ctrl_go,
   input logic             en_q,
   input logic             res_wr,
   input logic             busy,
   input logic             flag,
   input logic             sample,
   input logic             discharge,
   input logic [RES_W-1:0] dac_code,
   input logic [RES_W-1:0] result
);

   localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

   // R1
   switch_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(sample && discharge));

   // R2
   go_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
      (ctrl_wr && ctrl_go && !en_q) |=> !busy);

   // R4
   first_trial_chk: assert property (@(posedge clk) disable iff (rst)
      ($fell(discharge) && busy) |-> (dac_code == MSB_ONLY));

   // R6
   flag_on_done_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(flag) |-> $fell(busy));

   // R7
   result_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(result) |-> ($fell(busy) || $past(res_wr)));

   // R8
   recover_open_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> !sample);

endmodule

bind sar_seq sar_seq_chk #(.RES_W(RES_W)) u_chk (.*);

// File: tb/sar_seq_bench.sv
`timescale 1ns/1ps
module sar_seq_bench;

   localparam int W = 10;
   localparam logic [12:0] VEC [8] = '{
      {10'd0,    3'd0},
      {10'd1023, 3'd1},
      {10'd512,  3'd2},
      {10'd511,  3'd3},
      {10'h155,  3'd4},
      {10'h2AA,  3'd5},
      {10'd1,    3'd6},
      {10'd700,  3'd7}
   };

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         ctrl_wr = 1'b0, ctrl_en = 1'b0, ctrl_go = 1'b0;
   logic [2:0]   acq_code = 3'd0;
   logic         tad_tick;
   logic         cmp_ge;
   logic         res_wr = 1'b0;
   logic [W-1:0] res_wdata = '0;
   logic         flag_clr = 1'b0;
   logic         sample, discharge, busy, flag;
   logic [W-1:0] dac_code, result;
   logic [W-1:0] vin = '0;
   logic [1:0]   div = '0;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   always @(posedge clk) div <= div + 2'd1;
   assign tad_tick = (div == 2'd3);
   assign cmp_ge   = (vin >= dac_code);

   sar_seq u_sar_seq (
      .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_en(ctrl_en),
      .ctrl_go(ctrl_go), .acq_code(acq_code), .tad_tick(tad_tick),
      .cmp_ge(cmp_ge), .res_wr(res_wr), .res_wdata(res_wdata),
      .flag_clr(flag_clr), .sample(sample), .discharge(discharge),
      .dac_code(dac_code), .result(result), .busy(busy), .flag(flag)
   );

   function automatic int exp_acq(input int c);
      case (c)
         0: return 0;   1: return 2;   2: return 4;   3: return 6;
         4: return 8;   5: return 12;  6: return 16;  default: return 20;
      endcase
   endfunction

   task automatic chk(input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic wr_ctrl(input logic en, input logic go);
      @(negedge clk);
      ctrl_wr = 1'b1; ctrl_en = en; ctrl_go = go;
      @(negedge clk);
      ctrl_wr = 1'b0;
   endtask

   task automatic wr_res(input logic [W-1:0] v);
      @(negedge clk);
      res_wr = 1'b1; res_wdata = v;
      @(negedge clk);
      res_wr = 1'b0;
   endtask

   task automatic clr_flag();
      @(negedge clk);
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
   endtask

   task automatic wait_ticks(input int n);
      int seen = 0;
      while (seen < n) begin
         if (tad_tick) seen++;
         @(negedge clk);
      end
   endtask

   // counts ticks seen while sample is low, returns once sample is high
   task automatic measure_rec(output int t);
      t = 0;
      while (!sample) begin
         if (tad_tick) t++;
         @(negedge clk);
      end
   endtask

   task automatic run_conv(input int v, input int code, input bit poke_rec);
      int  ticks = 0, n = 0, last_at = 0, dis_ticks = 0, overlap = 0;
      int  first_c = 0, second_c = 0, rec_t;
      bit  got1 = 1'b0, got2 = 1'b0;
      vin = W'(v); acq_code = 3'(code);
      wr_ctrl(1'b1, 1'b1);
      chk("R2 start accepted, busy", int'(busy), 1);
      while (busy) begin
         if (sample && discharge) overlap++;
         if (tad_tick) begin
            ticks++;
            last_at = n;
            if (discharge) dis_ticks++;
         end
         if (dac_code != '0) begin
            if (!got1) begin
               first_c = int'(dac_code); got1 = 1'b1;
            end else if (!got2 && int'(dac_code) != first_c) begin
               second_c = int'(dac_code); got2 = 1'b1;
            end
         end
         @(negedge clk);
         n++;
      end
      chk("R3 busy TAD ticks", ticks, 12 + exp_acq(code));
      chk("R4 discharge ticks", dis_ticks, 1);
      chk("R4 first trial code", first_c, 512);
      chk("R5 second trial code", second_c, (v >= 512) ? 768 : 256);
      chk("R1 sample/discharge overlap", overlap, 0);
      chk("R6 clocks from last tick to done", n - last_at, 2);
      chk("R5 result value", int'(result), v);
      chk("R6 flag set", int'(flag), 1);
      chk("R8 sample open after done", int'(sample), 0);
      if (poke_rec) begin
         wr_ctrl(1'b1, 1'b1);
         chk("R8 start during recovery ignored", int'(busy), 0);
         measure_rec(rec_t);
         chk("R8 busy after recovery", int'(busy), 0);
      end else begin
         measure_rec(rec_t);
         chk("R8 recovery ticks", rec_t, 2);
      end
   endtask

   initial begin : watchdog
      #1000000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin : main
      int rec_t;
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk("R1 reset result", int'(result), 0);
      chk("R1 reset busy", int'(busy), 0);
      chk("R1 reset flag", int'(flag), 0);
      chk("R1 reset sample", int'(sample), 0);
      chk("R1 reset discharge", int'(discharge), 0);
      chk("R1 reset dac_code", int'(dac_code), 0);

      // R2: enable and start in one write
      wr_ctrl(1'b1, 1'b1);
      chk("R2 start with enable ignored", int'(busy), 0);
      chk("R1 idle enabled sample", int'(sample), 1);

      // table walk over every acquisition code
      for (int i = 0; i < 8; i++) begin
         clr_flag();
         chk("R9 flag cleared", int'(flag), 0);
         run_conv(int'(VEC[i][12:3]), int'(VEC[i][2:0]), 1'b0);
      end

      // R9 flag is sticky
      repeat (20) @(negedge clk);
      chk("R9 flag sticky", int'(flag), 1);
      clr_flag();
      chk("R9 flag cleared by flag_clr", int'(flag), 0);

      // R7 abandon keeps result 700
      vin = 10'd100; acq_code = 3'd0;
      wr_ctrl(1'b1, 1'b1);
      wait_ticks(5);
      wr_ctrl(1'b1, 1'b0);
      chk("R7 busy after abort", int'(busy), 0);
      chk("R7 result kept", int'(result), 700);
      chk("R7 sample open", int'(sample), 0);
      measure_rec(rec_t);
      chk("R8 recovery ticks after abort", rec_t, 2);
      chk("R7 flag not set", int'(flag), 0);

      // R8 start during recovery
      run_conv(333, 1, 1'b1);

      // R10 software write then next conversion
      wr_res(10'h0F0);
      chk("R10 sw write", int'(result), 240);
      repeat (30) @(negedge clk);
      chk("R10 sw value holds", int'(result), 240);
      clr_flag();
      run_conv(10'h321, 0, 1'b0);

      // R11 disable mid conversion
      clr_flag();
      vin = 10'd900; acq_code = 3'd2;
      wr_ctrl(1'b1, 1'b1);
      wait_ticks(7);
      wr_ctrl(1'b0, 1'b0);
      chk("R11 busy after disable", int'(busy), 0);
      chk("R11 sample after disable", int'(sample), 0);
      repeat (20) @(negedge clk);
      chk("R11 result kept", int'(result), 10'h321);
      chk("R11 flag not set", int'(flag), 0);
      chk("R11 discharge off", int'(discharge), 0);
      wr_ctrl(1'b1, 1'b0);
      chk("R1 re-enabled sample", int'(sample), 1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule